// File: doc/BRIEF.md
# Synchronous Serial FIFO Interrupt Generator

This block turns the occupancy counts of a synchronous serial port's receive and transmit FIFOs into two level interrupt requests for the system interrupt controller. Each FIFO holds up to 16 half-words, so each count runs from 0 to 16. The receive request is raised when the receive FIFO reaches the half-full mark. It is then held, with hysteresis, until software has drained the FIFO completely. The transmit request stays active for as long as the transmit FIFO holds fewer entries than the half mark, and it drops once the FIFO has been refilled to that mark.

Each direction has an enable bit from the system domain. A change to an enable bit does not act at once. The block samples the serial clock through a two-flop synchroniser and takes in a new enable value only on a detected rising edge of the serial clock. A disable therefore reaches the interrupts one serial-clock period late. While a direction is disabled, its request is forced low and the receive hysteresis state is dropped. Both outputs are registered. After reset, both requests are low and both directions count as disabled until the first serial clock edge.

Top module: `sfi_irq_top`

## Requirements
- R1: After a synchronous reset both rx_irq and tx_irq are 0, and both directions stay disabled until a serial clock rising edge is seen, whatever the enables and counts.
- R2: With receive effectively enabled, rx_count of 8 or more sets rx_irq on the following clock.
- R3: Once set, rx_irq stays 1 while rx_count is between 1 and 7. If rx_count rises from 0 to a value below 8, rx_irq is not set.
- R4: rx_irq clears on the clock after rx_count reads 0.
- R5: With transmit effectively enabled, tx_irq is 1 when tx_count is below 8 (including 0) and 0 when tx_count is 8 or more (including 16).
- R6: A change on rx_en or tx_en takes effect only after a rising edge of sclk. Until that edge, both interrupts behave according to the previous enable values.
- R7: A direction that is effectively disabled holds its interrupt at 0 for any count. After receive is re-enabled with rx_count between 1 and 7, rx_irq stays 0.
- R8: The receive and transmit enables act independently. Disabling one direction leaves the other direction's interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, sampled asynchronously |
| rx_en | input | 1 | Receive direction enable (system domain) |
| tx_en | input | 1 | Transmit direction enable (system domain) |
| rx_count | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_count | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_irq | output | 1 | Receive half-full request with hysteresis |
| tx_irq | output | 1 | Transmit below-half request |

## Verification
The hardest state to reach is a pending disable. In this state the enable has already dropped, no serial edge has followed yet, and the receive request must still be held from its hysteresis while the count sits between 1 and 7. The bench holds sclk still and drives the counts and enables through the armed state and then the disable. It checks that both requests stay up for several system clocks. Only then does it produce one serial clock pulse and check that both requests fall. It then re-enables receive with a partial FIFO to confirm that the hysteresis state did not survive.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;
  localparam int NUM_DIR = 2;

  typedef enum logic {
    RX_QUIET = 1'b0,
    RX_ARMED = 1'b1
  } rx_state_e;
endpackage

// File: rtl/sfi_edge_sync.sv
module sfi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  output logic tick
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], sclk};
  end

  assign tick = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/sfi_en_latch.sv
module sfi_en_latch (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic en_req,
  output logic en_eff
);
  always_ff @(posedge clk) begin
    if (rst)       en_eff <= 1'b0;
    else if (tick) en_eff <= en_req;
  end
endmodule

// File: rtl/sfi_rx_level.sv
module sfi_rx_level
  import sfi_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int HALF  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] count,
  output logic             irq
);
  rx_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    if (!en)                          state_nx = RX_QUIET;
    else if (count >= CNT_W'(HALF))   state_nx = RX_ARMED;
    else if (count == '0)             state_nx = RX_QUIET;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= RX_QUIET;
    else     state <= state_nx;
  end

  assign irq = (state == RX_ARMED);
endmodule

// File: rtl/sfi_tx_level.sv
module sfi_tx_level #(
  parameter int CNT_W = 5,
  parameter int HALF  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] count,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= en && (count < CNT_W'(HALF));
  end
endmodule

// File: rtl/sfi_irq_top.sv
module sfi_irq_top
  import sfi_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int HALF       = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  output logic             rx_irq,
  output logic             tx_irq
);
  logic               sclk_tick;
  logic [NUM_DIR-1:0] en_req;
  logic [NUM_DIR-1:0] en_eff;

  assign en_req[DIR_RX] = rx_en;
  assign en_req[DIR_TX] = tx_en;

  sfi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk),
    .tick (sclk_tick)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    sfi_en_latch u_lat (
      .clk    (clk),
      .rst    (rst),
      .tick   (sclk_tick),
      .en_req (en_req[d]),
      .en_eff (en_eff[d])
    );
  end

  sfi_rx_level #(.CNT_W(CNT_W), .HALF(HALF)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .en    (en_eff[DIR_RX]),
    .count (rx_count),
    .irq   (rx_irq)
  );

  sfi_tx_level #(.CNT_W(CNT_W), .HALF(HALF)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .en    (en_eff[DIR_TX]),
    .count (tx_count),
    .irq   (tx_irq)
  );
endmodule

// File: rtl/sfi_irq_chk.sv
module sfi_irq_chk #(
  parameter int CNT_W = 5,
  parameter int HALF  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             rx_eff,
  input logic             tx_eff,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count,
  input logic             rx_irq,
  input logic             tx_irq
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!rx_irq && !tx_irq && !rx_eff && !tx_eff));

  assert_rx_set_R2: assert property (@(posedge clk) disable iff (rst)
    (rx_eff && rx_count >= CNT_W'(HALF)) |=> rx_irq);

  assert_rx_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_irq && rx_eff && rx_count != '0) |=> rx_irq);

  assert_rx_no_early_R3: assert property (@(posedge clk) disable iff (rst)
    (!rx_irq && rx_count < CNT_W'(HALF)) |=> !rx_irq);

  assert_rx_empty_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_count == '0) |=> !rx_irq);

  assert_tx_low_level_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_eff && tx_count < CNT_W'(HALF)) |=> tx_irq);

  assert_tx_high_level_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_count >= CNT_W'(HALF)) |=> !tx_irq);

  assert_en_only_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(rx_eff) && $stable(tx_eff)));

  assert_rx_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    !rx_eff |=> !rx_irq);

  assert_tx_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    !tx_eff |=> !tx_irq);
endmodule

bind sfi_irq_top sfi_irq_chk #(.CNT_W(CNT_W), .HALF(HALF)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (sclk_tick),
  .rx_eff   (en_eff[0]),
  .tx_eff   (en_eff[1]),
  .rx_count (rx_count),
  .tx_count (tx_count),
  .rx_irq   (rx_irq),
  .tx_irq   (tx_irq)
);

// File: tb/sim_sfi_irq_top.sv
module sim_sfi_irq_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic rx_en = 1'b0;
  logic tx_en = 1'b0;
  logic [CW-1:0] rx_count = '0;
  logic [CW-1:0] tx_count = '0;
  logic rx_irq, tx_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfi_irq_top u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .rx_en(rx_en), .tx_en(tx_en),
    .rx_count(rx_count), .tx_count(tx_count), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic serial_edge();
    sclk = 1'b1;
    wait_clk(4);
    sclk = 1'b0;
    wait_clk(4);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    rx_en = 1'b1; tx_en = 1'b1;
    rx_count = 5'd12; tx_count = 5'd0;
    wait_clk(3);
    rst = 1'b0;
    check("R1 rx_irq after reset", rx_irq, 1'b0);
    check("R1 tx_irq after reset", tx_irq, 1'b0);
    wait_clk(6);
    check("R1 rx disabled until serial edge", rx_irq, 1'b0);
    check("R1 tx disabled until serial edge", tx_irq, 1'b0);
  endtask

  task automatic t_rx_hysteresis();
    rx_count = 5'd0;
    serial_edge();
    check("R4 rx idle when empty", rx_irq, 1'b0);
    rx_count = 5'd7; wait_clk(1);
    check("R3 rx not set below half", rx_irq, 1'b0);
    rx_count = 5'd8; wait_clk(1);
    check("R2 rx set at half", rx_irq, 1'b1);
    rx_count = 5'd16; wait_clk(1);
    check("R2 rx set when full", rx_irq, 1'b1);
    rx_count = 5'd3; wait_clk(2);
    check("R3 rx held while draining", rx_irq, 1'b1);
    rx_count = 5'd1; wait_clk(2);
    check("R3 rx held at one entry", rx_irq, 1'b1);
    rx_count = 5'd0; wait_clk(1);
    check("R4 rx cleared at empty", rx_irq, 1'b0);
    rx_count = 5'd5; wait_clk(2);
    check("R3 rx stays low rising below half", rx_irq, 1'b0);
    rx_count = 5'd0; wait_clk(1);
  endtask

  task automatic t_tx_levels();
    tx_count = 5'd0; wait_clk(1);
    check("R5 tx active when empty", tx_irq, 1'b1);
    tx_count = 5'd7; wait_clk(1);
    check("R5 tx active at seven", tx_irq, 1'b1);
    tx_count = 5'd8; wait_clk(1);
    check("R5 tx clear at half", tx_irq, 1'b0);
    tx_count = 5'd16; wait_clk(1);
    check("R5 tx clear when full", tx_irq, 1'b0);
    tx_count = 5'd2; wait_clk(1);
    check("R5 tx active again", tx_irq, 1'b1);
  endtask

  task automatic t_disable_delay();
    rx_count = 5'd10; tx_count = 5'd3; wait_clk(1);
    rx_count = 5'd4; wait_clk(1);
    check("R3 rx armed before disable", rx_irq, 1'b1);
    rx_en = 1'b0; tx_en = 1'b0;
    wait_clk(8);
    check("R6 rx still active pending sync", rx_irq, 1'b1);
    check("R6 tx still active pending sync", tx_irq, 1'b1);
    serial_edge();
    check("R6 rx cleared after serial edge", rx_irq, 1'b0);
    check("R6 tx cleared after serial edge", tx_irq, 1'b0);
    rx_count = 5'd14; tx_count = 5'd0; wait_clk(2);
    check("R7 rx forced low when disabled", rx_irq, 1'b0);
    check("R7 tx forced low when disabled", tx_irq, 1'b0);
  endtask

  task automatic t_reenable();
    rx_count = 5'd5;
    rx_en = 1'b1; tx_en = 1'b1;
    wait_clk(4);
    check("R6 tx stays low before serial edge", tx_irq, 1'b0);
    serial_edge();
    check("R7 rx hysteresis dropped on re-enable", rx_irq, 1'b0);
    check("R6 tx active after serial edge", tx_irq, 1'b1);
  endtask

  task automatic t_independent();
    rx_count = 5'd9; tx_count = 5'd1; wait_clk(1);
    check("R8 rx active both enabled", rx_irq, 1'b1);
    tx_en = 1'b0;
    serial_edge();
    check("R8 rx unaffected by tx disable", rx_irq, 1'b1);
    check("R8 tx disabled alone", tx_irq, 1'b0);
    tx_en = 1'b1; rx_en = 1'b0;
    serial_edge();
    check("R8 tx unaffected by rx disable", tx_irq, 1'b1);
    check("R8 rx disabled alone", rx_irq, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_clk(1);
    t_reset();
    t_rx_hysteresis();
    t_tx_levels();
    t_disable_delay();
    t_reenable();
    t_independent();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule